// File: doc/BRIEF.md
# Framed Serial Word Receiver

A write-only, three-wire serial slave that collects fixed-width command words for a host block in the master clock domain. A frame is open while the active-low frame strobe is held low. The strobe marks the frame and also enables the receiver. On every falling edge of the serial clock inside an open frame, one data bit is shifted in, most significant bit first. Each group of `WORD_W` falling edges forms one word, so a frame can carry one word or many back-to-back words.

The serial clock has no fixed relation to the master clock. The serial side keeps its bit counter, shift register and a completed-word register, all clocked by the serial clock. When a word completes, a toggle flag flips. The master side synchronizes that flag and turns each flip into a one-cycle `valid_o` pulse. The word appears on `data_o` in the same cycle. A frame that closes before a word completes leaves nothing behind, because a high strobe holds the bit counter at zero asynchronously.

The master clock must be fast enough to register several edges within one word time, which is `WORD_W` serial clock periods. The serial clock must be high when the strobe falls. It may run continuously or idle at either level between frames.

Top module: `sdin_word_rx`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `data_o` is all zeros.
- R2: Inside an open frame, bits are taken from `sdata_i` on falling edges of `sclk_i`. The first bit received lands in `data_o[WORD_W-1]` and the last in `data_o[0]`.
- R3: Each completed word produces exactly one `valid_o` pulse, one master clock cycle wide.
- R4: With the strobe held low for k·`WORD_W` falling edges, k words are delivered in the order they were sent. Each word starts on the edge after the previous one completed.
- R5: If the strobe rises before a word completes, the partial bits are discarded. No pulse is produced, and the next frame begins a fresh word at its first falling edge.
- R6: Serial clock edges while `sync_ni` is high produce no word. `valid_o` stays 0 and `data_o` keeps its value.
- R7: `data_o` changes only in a cycle in which `valid_o` is 1. Between pulses it holds the last delivered word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| sclk_i | input | 1 | Serial clock; data is sampled on its falling edge |
| sync_ni | input | 1 | Active-low frame strobe and receiver enable |
| sdata_i | input | 1 | Serial data, MSB first |
| valid_o | output | 1 | One-cycle pulse per delivered word |
| data_o | output | WORD_W | Last delivered word |

## Verification
The bench builds the block with `WORD_W` = 16 and `SYNC_STAGES` = 2. It runs a 40 ns serial clock against a 10 ns master clock, so each word spans 64 master cycles. That is well above the synchronizer latency, which lets every pulse be checked for width and order. A 16-bit word makes the all-ones, all-zeros and single-bit patterns cheap to drive, and it lets a 7-bit partial frame and a 3-word frame exercise the counter reset and wrap. With only two synchronizer stages, a pulse shows up within a handful of master cycles, so a fixed drain wait after each frame is enough to collect every delivery.

// File: rtl/sdin_pkg.sv
package sdin_pkg;
  localparam int unsigned WORD_W_DEF  = 16;
  localparam int unsigned SYNC_ST_DEF = 2;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sdin_shift_in.sv
module sdin_shift_in #(
  parameter int unsigned WORD_W = sdin_pkg::WORD_W_DEF,
  localparam int unsigned CNT_W = sdin_pkg::cnt_width(WORD_W)
) (
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              sync_ni,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] word_o,
  output logic              tgl_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic              frame_rst_n;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] shift_nxt;
  logic              last_bit;

  // high strobe holds the counter at zero regardless of the serial clock
  assign frame_rst_n = rst_ni & ~sync_ni;
  assign last_bit    = (cnt_q == CNT_W'(WORD_W - 1));
  assign shift_nxt   = {shift_q[WORD_W-2:0], sdata_i};

  always_ff @(negedge sclk_i or negedge frame_rst_n) begin
    if (!frame_rst_n) cnt_q <= '0;
    else if (last_bit) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(negedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) shift_q <= '0;
    else if (!sync_ni) shift_q <= shift_nxt;
  end

  // word register and toggle survive frame end for the crossing
  always_ff @(negedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      tgl_o  <= 1'b0;
    end else if (!sync_ni && last_bit) begin
      word_o <= shift_nxt;
      tgl_o  <= ~tgl_o;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sdin_toggle_cdc.sv
module sdin_toggle_cdc #(
  parameter int unsigned WORD_W      = sdin_pkg::WORD_W_DEF,
  parameter int unsigned SYNC_STAGES = sdin_pkg::SYNC_ST_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tgl_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   seen_q;
  logic                   flip;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b0;
        else sync_q[0] <= tgl_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b0;
        else sync_q[s] <= sync_q[s-1];
      end
    end
  end

  assign flip = sync_q[SYNC_STAGES-1] ^ seen_q;

  // word_i is stable: it only changes WORD_W serial clocks after a flip
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      seen_q  <= sync_q[SYNC_STAGES-1];
      valid_o <= flip;
      if (flip) data_o <= word_i;
    end
  end
endmodule

// File: rtl/sdin_word_rx.sv
module sdin_word_rx #(
  parameter int unsigned WORD_W      = sdin_pkg::WORD_W_DEF,
  parameter int unsigned SYNC_STAGES = sdin_pkg::SYNC_ST_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sync_ni,
  input  logic              sdata_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o
);
  localparam int unsigned CNT_W = sdin_pkg::cnt_width(WORD_W);

  logic [WORD_W-1:0] word_hold;
  logic              word_tgl;
  logic [CNT_W-1:0]  bit_cnt;

  sdin_shift_in #(.WORD_W(WORD_W)) i_shift (
    .sclk_i (sclk_i),
    .rst_ni (rst_ni),
    .sync_ni(sync_ni),
    .sdata_i(sdata_i),
    .word_o (word_hold),
    .tgl_o  (word_tgl),
    .cnt_o  (bit_cnt)
  );

  sdin_toggle_cdc #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) i_cdc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tgl_i  (word_tgl),
    .word_i (word_hold),
    .valid_o(valid_o),
    .data_o (data_o)
  );
endmodule

// File: rtl/sdin_word_rx_chk.sv
module sdin_word_rx_chk #(
  parameter int unsigned WORD_W = sdin_pkg::WORD_W_DEF,
  localparam int unsigned CNT_W = sdin_pkg::cnt_width(WORD_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sclk_i,
  input logic              sync_ni,
  input logic              valid_o,
  input logic [WORD_W-1:0] data_o,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              word_tgl
);
  logic seen_q;

  always_ff @(negedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else seen_q <= 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (!valid_o && data_o == '0);
    end
  end

  assert_single_pulse_R3: assert property (
    @(posedge clk_i) disable iff (!rst_ni) valid_o |=> !valid_o);

  assert_hold_between_R7: assert property (
    @(posedge clk_i) disable iff (!rst_ni) !$stable(data_o) |-> valid_o);

  assert_wrap_after_word_R4: assert property (
    @(negedge sclk_i) disable iff (!rst_ni)
      (seen_q && (word_tgl != $past(word_tgl))) |-> (bit_cnt == '0));

  assert_word_needs_frame_R6: assert property (
    @(negedge sclk_i) disable iff (!rst_ni)
      (seen_q && (word_tgl != $past(word_tgl))) |-> !$past(sync_ni));
endmodule

bind sdin_word_rx sdin_word_rx_chk #(.WORD_W(WORD_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sclk_i  (sclk_i),
  .sync_ni (sync_ni),
  .valid_o (valid_o),
  .data_o  (data_o),
  .bit_cnt (bit_cnt),
  .word_tgl(word_tgl)
);

// File: tb/test_sdin_word_rx.sv
module test_sdin_word_rx;
  localparam int CLK_PERIOD = 10;
  localparam int SCLK_HALF  = 20;
  localparam int W          = 16;
  localparam int NVEC       = 8;
  localparam logic [W-1:0] VEC [NVEC] = '{
    16'hA5C3, 16'h0000, 16'hFFFF, 16'h8000,
    16'h0001, 16'h5A5A, 16'h1234, 16'hFEDC
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic sclk_i = 1'b1;
  logic sync_ni = 1'b1;
  logic sdata_i = 1'b0;
  logic valid_o;
  logic [W-1:0] data_o;

  int checks = 0;
  int errors = 0;
  int rx_cnt = 0;
  int wide_cnt = 0;
  logic prev_valid = 1'b0;
  logic [W-1:0] rx_data [64];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sdin_word_rx #(.WORD_W(W), .SYNC_STAGES(2)) i_sdin_word_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .sync_ni(sync_ni),
    .sdata_i(sdata_i), .valid_o(valid_o), .data_o(data_o)
  );

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (valid_o) begin
        if (rx_cnt < 64) rx_data[rx_cnt] = data_o;
        rx_cnt = rx_cnt + 1;
        if (prev_valid) wide_cnt = wide_cnt + 1;
      end
      prev_valid = valid_o;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdata_i = b;
    #(SCLK_HALF) sclk_i = 1'b0;
    #(SCLK_HALF) sclk_i = 1'b1;
  endtask

  task automatic send_word(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic drain();
    repeat (16) @(posedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    int base;
    logic [W-1:0] held;
    #2 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check(valid_o == 1'b0, "R1 valid", 32'(valid_o), 32'd0);
    check(data_o == '0, "R1 data", 32'(data_o), 32'd0);
    rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);

    // R2: one word per frame, table driven
    for (int v = 0; v < NVEC; v++) begin
      base = rx_cnt;
      sync_ni = 1'b0;
      #(SCLK_HALF);
      send_word(VEC[v]);
      sync_ni = 1'b1;
      drain();
      check(rx_cnt == base + 1, "R3 pulse count", 32'(rx_cnt - base), 32'd1);
      check(rx_data[base] == VEC[v], "R2 word", 32'(rx_data[base]), 32'(VEC[v]));
    end

    // R4: three words in one frame
    base = rx_cnt;
    sync_ni = 1'b0;
    #(SCLK_HALF);
    send_word(16'hC001);
    send_word(16'h7E57);
    send_word(16'h0F0F);
    sync_ni = 1'b1;
    drain();
    check(rx_cnt == base + 3, "R4 count", 32'(rx_cnt - base), 32'd3);
    check(rx_data[base] == 16'hC001, "R4 word0", 32'(rx_data[base]), 32'hC001);
    check(rx_data[base+1] == 16'h7E57, "R4 word1", 32'(rx_data[base+1]), 32'h7E57);
    check(rx_data[base+2] == 16'h0F0F, "R4 word2", 32'(rx_data[base+2]), 32'h0F0F);

    // R5: 7-bit partial frame discarded, next frame aligned
    base = rx_cnt;
    sync_ni = 1'b0;
    #(SCLK_HALF);
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    sync_ni = 1'b1;
    drain();
    check(rx_cnt == base, "R5 no pulse", 32'(rx_cnt - base), 32'd0);
    sync_ni = 1'b0;
    #(SCLK_HALF);
    send_word(16'h2468);
    sync_ni = 1'b1;
    drain();
    check(rx_cnt == base + 1, "R5 count", 32'(rx_cnt - base), 32'd1);
    check(data_o == 16'h2468, "R5 word", 32'(data_o), 32'h2468);

    // R6/R7: clocks with strobe high do nothing
    base = rx_cnt;
    held = data_o;
    for (int i = 0; i < 40; i++) send_bit(i[0]);
    drain();
    check(rx_cnt == base, "R6 no pulse", 32'(rx_cnt - base), 32'd0);
    check(data_o == held, "R7 hold", 32'(data_o), 32'(held));

    // idle-low serial clock between frames, raised before strobe falls
    sclk_i = 1'b0;
    repeat (10) @(posedge clk_i);
    sclk_i = 1'b1;
    #(SCLK_HALF);
    base = rx_cnt;
    sync_ni = 1'b0;
    #(SCLK_HALF);
    send_word(16'h9BDF);
    sync_ni = 1'b1;
    drain();
    check(rx_cnt == base + 1 && data_o == 16'h9BDF, "R2 idle-low word",
          32'(data_o), 32'h9BDF);

    check(wide_cnt == 0, "R3 width", 32'(wide_cnt), 32'd0);
    finish_run();
  end
endmodule